// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Synthesizer

This block is a numerically controlled oscillator that drives two 8-bit DAC codes from one shared phase. A 16-bit phase accumulator adds a programmable increment on every tick. A tick comes from one of two strobe inputs. The first is a slow reference strobe, thinned by a 3-bit pre-divider. The second is a fixed reference strobe used as it arrives. The top eight phase bits address a 256-entry signed cosine table, which is computed when the design is elaborated.

Each of the two channels processes the shared sample on its own. It applies an arithmetic right shift for amplitude, adds an offset with wraparound, and applies one of four bit-inversion patterns. The result is held in an output register. A channel that is switched off, or left idle by the global tone switch, parks at midscale. Software programs the block through a plain write port with three decoded addresses.

Top module: `cos_tone_gen`

## Requirements
- R1: While reset is asserted and right after it, both DAC codes read 0x80 and the phase reads 0. All control fields reset to zero.
- R2: A write at address 0 loads the global fields: increment in bits [15:0], tone switch in bit 16, pre-divider in bits [19:17], and source select in bit 20 (1 means fixed strobe). A write at address 1 loads channel A and a write at address 2 loads channel B. Each channel uses offset in bits [7:0], scale in bits [9:8], inversion code in bits [11:10], and channel switch in bit 12. A write at address 3 changes nothing.
- R3: With the slow source selected and pre-divider d, a tick occurs on every (d+1)-th slow strobe counted from reset. The fixed strobe is then ignored.
- R4: With the fixed source selected, every fixed strobe is a tick. Slow strobes and the pre-divider then have no effect.
- R5: Each tick with the tone switch on adds the increment to the phase modulo 65536. After N ticks from phase 0, the phase has wrapped floor(N*step/65536) times.
- R6: While the tone switch is off, the phase holds its value and both DAC codes read 0x80.
- R7: A channel whose channel switch is off reads 0x80, whatever the other channel does.
- R8: The table entry for index i = phase[15:8], with q = i mod 64 and A(x) = 127 - floor(127*x*x/4096), is +A(q), -A(64-q), -A(q) and +A(64-q) for quadrants i/64 = 0, 1, 2 and 3.
- R9: Scale code k (0..3) shifts the signed sample right arithmetically by k bits, giving full, 1/2, 1/4 and 1/8 amplitude.
- R10: The 8-bit offset is added to the scaled sample modulo 256.
- R11: Inversion is applied after the offset. Code 00 leaves the value unchanged, 01 flips all bits, 10 flips bit 7 only, and 11 flips bits 6..0.
- R12: A DAC code reflects the phase and settings of the previous cycle, through one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_stb | input | 1 | Slow reference strobe, one clock wide |
| fixed_stb | input | 1 | Fixed reference strobe, one clock wide |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| phase_o | output | 16 | Current accumulator phase |
| dac_a | output | 8 | Channel A DAC code |
| dac_b | output | 8 | Channel B DAC code |

## Verification
The hardest situation to reach from the ports is a long run of ticks under a given pre-divider setting. Here the exact tick count, and so the final phase and wrap count, depends on the divider counter state, which is never visible. The bench resets before each such run so the counter starts from zero. It then issues a known number of slow strobes with random gaps, with distractor fixed strobes mixed in. Finally it compares the phase and the observed wrap count against the arithmetic expected for every divider value and for extreme increments. The ordering of inversion after offset is reached by parking the phase at a known table point and choosing offsets for which the two possible orderings give different codes.

// File: rtl/cos_tone_pkg.sv
`timescale 1ns/1ps
package cos_tone_pkg;
  localparam int DAC_W  = 8;
  localparam int LUT_AW = 8;
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int QTR    = LUT_N / 4;
  localparam int AMP    = (1 << (DAC_W - 1)) - 1;
  localparam logic [DAC_W-1:0] MID_CODE = {1'b1, {(DAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ALL  = 2'd1,
    INV_MSB  = 2'd2,
    INV_LOW  = 2'd3
  } inv_mode_e;

  typedef struct packed {
    logic              en;
    inv_mode_e         inv;
    logic [1:0]        scale;
    logic [DAC_W-1:0]  offset;
  } chan_cfg_t;

  // Parabolic quarter-wave magnitude: AMP at x = 0, zero at x = QTR.
  function automatic int quarter_mag(int x);
    return AMP - (AMP * x * x) / (QTR * QTR);
  endfunction

  function automatic logic signed [DAC_W-1:0] cos_entry(int idx);
    int q;
    int v;
    q = idx % QTR;
    case (idx / QTR)
      0:       v = quarter_mag(q);
      1:       v = -quarter_mag(QTR - q);
      2:       v = -quarter_mag(q);
      default: v = quarter_mag(QTR - q);
    endcase
    return DAC_W'(v);
  endfunction
endpackage

// File: rtl/cos_tick_div.sv
`timescale 1ns/1ps
module cos_tick_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_stb,
  input  logic             fixed_stb,
  input  logic             src_fixed,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    tick  = 1'b0;
    if (src_fixed) begin
      cnt_d = '0;
      tick  = fixed_stb;
    end else if (slow_stb) begin
      if (cnt_q >= div) begin
        cnt_d = '0;
        tick  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  slow_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !src_fixed) |-> slow_stb);

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_fixed && tick && div != '0) |=> (src_fixed || div != $past(div) || !tick));
endmodule

// File: rtl/cos_phase_acc.sv
`timescale 1ns/1ps
module cos_phase_acc #(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic [PH_W-1:0] step,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] phase_q, phase_d;
  logic            adv;

  always_comb begin
    adv     = run & tick;
    phase_d = phase_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (adv) phase_q <= phase_d;
  end

  assign phase = phase_q;

  // R6
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(phase_q));

  // R5
  phase_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && step != '0) |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/cos_chan_post.sv
`timescale 1ns/1ps
module cos_chan_post
  import cos_tone_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic signed [DAC_W-1:0] sample,
  input  chan_cfg_t               cfg,
  output logic [DAC_W-1:0]        code
);
  localparam logic signed [DAC_W-1:0] SC3_HI = DAC_W'(AMP / 8);
  localparam logic signed [DAC_W-1:0] SC3_LO = DAC_W'(-(AMP + 1) / 8);

  logic signed [DAC_W-1:0] scaled;
  logic [DAC_W-1:0]        summed, flipped, code_d, code_q;

  always_comb begin
    scaled = sample >>> cfg.scale;
    summed = scaled + cfg.offset;
    case (cfg.inv)
      INV_ALL: flipped = ~summed;
      INV_MSB: flipped = summed ^ MID_CODE;
      INV_LOW: flipped = summed ^ ~MID_CODE;
      default: flipped = summed;
    endcase
    code_d = active ? flipped : MID_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= MID_CODE;
    else        code_q <= code_d;
  end

  assign code = code_q;

  // R7
  idle_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (code_q == MID_CODE));

  // R9
  scale3_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cfg.scale == 2'd3 && cfg.inv == INV_NONE) |=>
      ($signed(code_q - $past(cfg.offset)) <= SC3_HI &&
       $signed(code_q - $past(cfg.offset)) >= SC3_LO));
endmodule

// File: rtl/cos_tone_gen.sv
`timescale 1ns/1ps
module cos_tone_gen
  import cos_tone_pkg::*;
#(
  parameter int PH_W  = 16,
  parameter int DIV_W = 3,
  parameter int CFG_W = 32,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_stb,
  input  logic             fixed_stb,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [PH_W-1:0]  phase_o,
  output logic [DAC_W-1:0] dac_a,
  output logic [DAC_W-1:0] dac_b
);
  localparam int N_CH     = 2;
  localparam int TEN_BIT  = PH_W;
  localparam int DIV_LSB  = PH_W + 1;
  localparam int SEL_BIT  = DIV_LSB + DIV_W;
  localparam int SC_LSB   = DAC_W;
  localparam int INV_LSB  = DAC_W + 2;
  localparam int CHEN_BIT = DAC_W + 4;
  localparam logic [AW-1:0] A_GLOB = '0;

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // Control registers
  logic [PH_W-1:0]  step_q, step_d;
  logic             ten_q, ten_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             fix_q, fix_d;
  chan_cfg_t        chan_q [N_CH];
  chan_cfg_t        chan_d [N_CH];
  logic             unused_wdata;

  assign unused_wdata = ^cfg_wdata[CFG_W-1:SEL_BIT+1];

  always_comb begin
    step_d = step_q;
    ten_d  = ten_q;
    div_d  = div_q;
    fix_d  = fix_q;
    for (int c = 0; c < N_CH; c++) chan_d[c] = chan_q[c];
    if (cfg_we) begin
      if (cfg_addr == A_GLOB) begin
        step_d = cfg_wdata[PH_W-1:0];
        ten_d  = cfg_wdata[TEN_BIT];
        div_d  = cfg_wdata[SEL_BIT-1:DIV_LSB];
        fix_d  = cfg_wdata[SEL_BIT];
      end
      for (int c = 0; c < N_CH; c++) begin
        if (cfg_addr == AW'(c + 1)) begin
          chan_d[c].offset = cfg_wdata[DAC_W-1:0];
          chan_d[c].scale  = cfg_wdata[SC_LSB+1:SC_LSB];
          chan_d[c].inv    = inv_mode_e'(cfg_wdata[INV_LSB+1:INV_LSB]);
          chan_d[c].en     = cfg_wdata[CHEN_BIT];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      step_q <= '0;
      ten_q  <= 1'b0;
      div_q  <= '0;
      fix_q  <= 1'b0;
      for (int c = 0; c < N_CH; c++) chan_q[c] <= '0;
    end else begin
      step_q <= step_d;
      ten_q  <= ten_d;
      div_q  <= div_d;
      fix_q  <= fix_d;
      for (int c = 0; c < N_CH; c++) chan_q[c] <= chan_d[c];
    end
  end

  // Tick generation and phase
  logic tick;

  cos_tick_div #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .slow_stb  (slow_stb),
    .fixed_stb (fixed_stb),
    .src_fixed (fix_q),
    .div       (div_q),
    .tick      (tick)
  );

  logic [PH_W-1:0] phase;

  cos_phase_acc #(.PH_W(PH_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (ten_q),
    .tick  (tick),
    .step  (step_q),
    .phase (phase)
  );

  assign phase_o = phase;

  // Cosine table, filled at elaboration
  logic signed [DAC_W-1:0] lut [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign lut[g] = cos_entry(g);
  end

  logic signed [DAC_W-1:0] sample;
  assign sample = lut[phase[PH_W-1 -: LUT_AW]];

  // Per-channel post-processing
  logic [DAC_W-1:0] code [N_CH];
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    cos_chan_post u_post (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .active (ten_q & chan_q[c].en),
      .sample (sample),
      .cfg    (chan_q[c]),
      .code   (code[c])
    );
  end

  assign dac_a = code[0];
  assign dac_b = code[1];
endmodule

// File: tb/cos_tone_gen_bench.sv
`timescale 1ns/1ps
module cos_tone_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        slow_stb, fixed_stb, cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [15:0] phase_o;
  logic [7:0]  dac_a, dac_b;

  cos_tone_gen u_cos_tone_gen (
    .clk(clk), .rst_n(rst_n), .slow_stb(slow_stb), .fixed_stb(fixed_stb),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .phase_o(phase_o), .dac_a(dac_a), .dac_b(dac_b)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // shadow of the control fields, as loaded at the last edge
  int sh_step, sh_ten, sh_div, sh_fix;
  int sh_off[2], sh_sc[2], sh_inv[2], sh_en[2];
  bit pend; int pend_a; logic [31:0] pend_d;
  bit pv, auto_on;
  int pv_ph, pv_ten;
  int pv_off[2], pv_sc[2], pv_inv[2], pv_en[2];
  int wraps, last_ph;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int quart(int x);
    return 127 - (127 * x * x) / 4096;
  endfunction

  function automatic int cos_ref(int idx);
    int q = idx % 64;
    case (idx / 64)
      0: return quart(q);
      1: return -quart(64 - q);
      2: return -quart(q);
      default: return quart(64 - q);
    endcase
  endfunction

  function automatic int post_ref(int idx, int sc, int off, int inv, int act);
    int s, v;
    if (act == 0) return 128;
    s = cos_ref(idx) >>> sc;
    v = (s + off) & 255;
    case (inv)
      1: v = v ^ 255;
      2: v = v ^ 128;
      3: v = v ^ 127;
      default: ;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] gw(int s, int en, int d, int fx);
    return {11'b0, fx[0], d[2:0], en[0], s[15:0]};
  endfunction

  function automatic logic [31:0] cw(int off, int sc, int inv, int en);
    return {19'b0, en[0], inv[1:0], sc[1:0], off[7:0]};
  endfunction

  task automatic shadow_reset();
    sh_step = 0; sh_ten = 0; sh_div = 0; sh_fix = 0;
    for (int c = 0; c < 2; c++) begin
      sh_off[c] = 0; sh_sc[c] = 0; sh_inv[c] = 0; sh_en[c] = 0;
    end
  endtask

  task automatic apply_pending();
    int c;
    if (pend_a == 0) begin
      sh_step = int'(pend_d[15:0]); sh_ten = int'(pend_d[16]);
      sh_div = int'(pend_d[19:17]); sh_fix = int'(pend_d[20]);
    end else if (pend_a == 1 || pend_a == 2) begin
      c = pend_a - 1;
      sh_off[c] = int'(pend_d[7:0]); sh_sc[c] = int'(pend_d[9:8]);
      sh_inv[c] = int'(pend_d[11:10]); sh_en[c] = int'(pend_d[12]);
    end
  endtask

  // One clock: sample after the edge, compare, update model, clear strobes.
  task automatic cycle();
    int e0, e1;
    @(posedge clk); #1;
    if (auto_on && pv) begin
      e0 = post_ref(pv_ph >> 8, pv_sc[0], pv_off[0], pv_inv[0], pv_ten & pv_en[0]);
      e1 = post_ref(pv_ph >> 8, pv_sc[1], pv_off[1], pv_inv[1], pv_ten & pv_en[1]);
      chk(int'(dac_a) == e0, "R8 R9 R10 R11 R12 channel A model", dac_a, e0);
      chk(int'(dac_b) == e1, "R8 R9 R10 R11 R12 channel B model", dac_b, e1);
    end
    if (int'(phase_o) < last_ph) wraps++;
    last_ph = int'(phase_o);
    if (pend) apply_pending();
    pend = 0;
    if (auto_on) begin
      pv = 1; pv_ph = int'(phase_o); pv_ten = sh_ten;
      for (int c = 0; c < 2; c++) begin
        pv_off[c] = sh_off[c]; pv_sc[c] = sh_sc[c];
        pv_inv[c] = sh_inv[c]; pv_en[c] = sh_en[c];
      end
    end
    slow_stb = 0; fixed_stb = 0; cfg_we = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = d;
    pend = 1; pend_a = a; pend_d = d;
    cycle();
  endtask

  task automatic do_reset();
    auto_on = 0; pv = 0; pend = 0;
    rst_n = 0;
    repeat (3) cycle();
    rst_n = 1;
    repeat (3) cycle();
    shadow_reset();
    wraps = 0; last_ph = int'(phase_o);
    auto_on = 1;
    cycle();
  endtask

  task automatic run_slow(int d, int s, int k);
    longint tot;
    int ticks;
    do_reset();
    wr(1, cw(0, 0, 2, 1));
    wr(0, gw(s, 1, d, 0));
    for (int i = 0; i < k; i++) begin
      slow_stb = 1; fixed_stb = 1'($urandom % 2);
      cycle();
      repeat ($urandom % 3) cycle();
    end
    cycle();
    ticks = k / (1 + d);
    tot = longint'(s) * ticks;
    chk(longint'(phase_o) == tot % 65536, "R3 R5 slow divided phase", phase_o, tot % 65536);
    chk(longint'(wraps) == tot / 65536, "R5 wrap count slow source", wraps, tot / 65536);
  endtask

  task automatic run_fixed(int s, int n);
    longint tot;
    int cnt = 0;
    do_reset();
    wr(0, gw(s, 1, 7, 1));
    while (cnt < n) begin
      slow_stb = 1'($urandom % 2);
      if ($urandom % 3 != 0) begin fixed_stb = 1; cnt++; end
      cycle();
    end
    cycle();
    tot = longint'(s) * n;
    chk(longint'(phase_o) == tot % 65536, "R4 R5 fixed source phase", phase_o, tot % 65536);
    chk(longint'(wraps) == tot / 65536, "R5 wrap count fixed source", wraps, tot / 65536);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] qexp [4];
    logic [7:0] iexp [4];
    logic [7:0] sexp [4];
    int offs [5];
    int h;
    void'($urandom(32'd24680));
    rst_n = 0; slow_stb = 0; fixed_stb = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    pend = 0; pv = 0; auto_on = 0; wraps = 0; last_ph = 0;
    shadow_reset();
    @(posedge clk); #1;
    chk(dac_a == 8'h80, "R1 code A during reset", dac_a, 8'h80);
    do_reset();
    chk(dac_a == 8'h80, "R1 code A after reset", dac_a, 8'h80);
    chk(dac_b == 8'h80, "R1 code B after reset", dac_b, 8'h80);
    chk(phase_o == 16'h0, "R1 phase after reset", phase_o, 0);

    // Quadrant points of the table and output latency
    qexp = '{8'h7F, 8'h00, 8'h81, 8'h00};
    wr(1, cw(0, 0, 0, 1));
    wr(0, gw(16'h4000, 1, 0, 1));
    cycle(); cycle();
    for (int i = 0; i < 4; i++) begin
      chk(dac_a == qexp[i], "R8 quadrant point", dac_a, qexp[i]);
      fixed_stb = 1; cycle();
      chk(dac_a == qexp[i], "R12 code lags phase one cycle", dac_a, qexp[i]);
      chk(int'(phase_o) == ((i + 1) * 16384) % 65536, "R5 phase step", phase_o, ((i + 1) * 16384) % 65536);
      cycle();
    end

    // Inversion after offset, sample +127 at phase 0
    iexp = '{8'h8F, 8'h70, 8'h0F, 8'hF0};
    for (int k = 0; k < 4; k++) begin
      wr(1, cw(8'h10, 0, k, 1)); cycle();
      chk(dac_a == iexp[k], "R11 inversion after offset", dac_a, iexp[k]);
    end
    wr(1, cw(8'hFF, 0, 0, 1)); cycle();
    chk(dac_a == 8'h7E, "R10 offset wraps modulo 256", dac_a, 8'h7E);

    // Arithmetic scaling of -127 at phase 0x8000
    sexp = '{8'h81, 8'hC0, 8'hE0, 8'hF0};
    wr(0, gw(16'h8000, 1, 0, 1));
    fixed_stb = 1; cycle();
    for (int k = 0; k < 4; k++) begin
      wr(1, cw(0, k, 0, 1)); cycle();
      chk(dac_a == sexp[k], "R9 arithmetic scale", dac_a, sexp[k]);
    end

    // Channel switch
    wr(2, cw(8'h33, 1, 2, 0)); cycle();
    chk(dac_b == 8'h80, "R7 channel B off reads midscale", dac_b, 8'h80);
    chk(dac_a == 8'hF0, "R7 channel A unaffected", dac_a, 8'hF0);
    wr(2, cw(0, 0, 0, 1)); cycle();
    chk(dac_b == 8'h81, "R7 channel B back on", dac_b, 8'h81);

    // Tone switch off
    wr(0, gw(16'h0123, 0, 0, 1));
    h = int'(phase_o);
    repeat (10) begin fixed_stb = 1; cycle(); end
    chk(int'(phase_o) == h, "R6 phase held", phase_o, h);
    chk(dac_a == 8'h80, "R6 code A midscale", dac_a, 8'h80);
    chk(dac_b == 8'h80, "R6 code B midscale", dac_b, 8'h80);

    // Address 3 has no effect
    wr(0, gw(16'h0100, 1, 0, 1));
    h = int'(phase_o);
    wr(3, 32'h0);
    repeat (4) begin fixed_stb = 1; cycle(); end
    cycle();
    chk(int'(phase_o) == (h + 4 * 256) % 65536, "R2 address 3 ignored", phase_o, (h + 4 * 256) % 65536);

    // Every scale x invert x offset combination against the model
    offs = '{0, 8'h7F, 8'h80, 8'hFF, 0};
    for (int sc = 0; sc < 4; sc++)
      for (int iv = 0; iv < 4; iv++)
        for (int oi = 0; oi < 5; oi++) begin
          wr(1, cw((oi == 4) ? int'($urandom % 256) : offs[oi], sc, iv, 1));
          wr(2, cw(int'($urandom % 256), int'($urandom % 4), int'($urandom % 4), int'($urandom % 2)));
          wr(0, gw(int'($urandom % 65535) + 1, 1, 0, 1));
          repeat (10) begin fixed_stb = 1'($urandom % 2); cycle(); end
        end

    // Divider and wrap counts
    for (int d = 0; d < 8; d++) run_slow(d, int'($urandom % 65535) + 1, 120);
    run_slow(0, 65535, 100);
    run_slow(3, 1, 50);
    run_fixed(int'($urandom % 65535) + 1, 150);
    run_fixed(65535, 200);

    // Random mix
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) begin
        cfg_we = 1; pend = 1;
        pend_a = int'($urandom % 4); pend_d = $urandom;
        cfg_addr = 2'(pend_a); cfg_wdata = pend_d;
      end
      slow_stb = 1'($urandom % 2);
      fixed_stb = 1'($urandom % 2);
      cycle();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule